// File: doc/BRIEF.md
# FP32 to bfloat16 Narrowing Converter

This block converts a stream of IEEE 754 single-precision words into 16-bit bfloat16 words. The sign bit and the full 8-bit exponent carry over unchanged, so the dynamic range stays the same. The mantissa is cut to its top 7 bits, and the discarded lower half of the word decides the rounding. A NaN input is detected before any rounding takes place. It always leaves the block as a quiet NaN, so the rounding step can never turn it into infinity.

Words enter and leave through valid/ready handshakes, one 32-bit word in and one 16-bit word out per transfer. A per-word mode bit selects the rounding rule. One rule adds the most significant discarded bit. The other rounds to nearest with ties to even. The result sits in a registered output stage together with two status flags: one marks a NaN result, and the other marks a finite input that rounded up to infinity. The output stage accepts a new word in any cycle where its slot is free or is being drained, so a continuous stream moves at one word per cycle.

Top module: `f32_bf16_narrow`

## Requirements
- R1: An input is a NaN exactly when its bits [30:0] form a value strictly greater than 0x7F800000. For such an input, out_data_o is input bits [31:16] with bit 6 (mask 0x0040) set to 1, out_nan_o is 1 and out_ovf_o is 0, whatever the mode.
- R2: With in_mode_i = 0 and a non-NaN input, out_data_o equals input bits [31:16] plus input bit 15, taken modulo 2^16.
- R3: With in_mode_i = 1 and a non-NaN input, out_data_o equals bits [31:16] of (input + 0x7FFF + input bit 16). An exact tie, where bits [15:0] are 0x8000, therefore rounds toward an even bit 0 of the result.
- R4: The input 0x3E800000 gives 0x3E80 in both modes.
- R5: A finite input (bits [30:23] not all ones) whose rounded result has exponent bits [14:7] all ones gives the signed infinity 0x7F80 or 0xFF80 with out_ovf_o = 1. In every other case out_ovf_o is 0. out_nan_o and out_ovf_o are never 1 together.
- R6: The infinities 0x7F800000 and 0xFF800000 give 0x7F80 and 0xFF80 with both flags 0. The zeros 0x00000000 and 0x80000000 give 0x0000 and 0x8000.
- R7: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_data_o, out_nan_o and out_ovf_o do not change.
- R8: in_ready_o is 1 whenever out_ready_i is 1 or out_valid_o is 0. A word accepted at a clock edge, together with the mode sampled at that edge, appears on the outputs with out_valid_o = 1 after that same edge. A continuous stream therefore moves at one word per cycle.
- R9: While rst_ni is low, out_valid_o, out_nan_o and out_ovf_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word present |
| in_ready_o | output | 1 | Converter can take a word this cycle |
| in_data_i | input | 32 | Single-precision input word |
| in_mode_i | input | 1 | 0: add most significant discarded bit, 1: nearest-even |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result this cycle |
| out_data_o | output | 16 | bfloat16 result |
| out_nan_o | output | 1 | Result is a quiet NaN |
| out_ovf_o | output | 1 | Finite input rounded up to infinity |

## Verification
Every result is due on the clock edge that accepts its input word, so one register stands between the two, and it stays there until the edge at which out_ready_i is high. The driver records the expected word, the NaN flag and the overflow flag in a queue at the accepting edge. The monitor samples on falling edges and pops one entry only when out_valid_o and out_ready_i are both high, so it lines up with the handshake and not with a fixed delay. While the consumer stalls, the monitor also checks on each falling edge that the held result has not moved, and a stream test checks that in_ready_o stays high for one word per cycle.

// File: rtl/f2b_pkg.sv
package f2b_pkg;
  localparam int unsigned WIDE_W   = 32;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned EXP_W    = 8;
  localparam int unsigned DROP_W   = WIDE_W - NARROW_W;
  localparam int unsigned FRAC_N   = NARROW_W - 1 - EXP_W;

  typedef enum logic {
    RND_GUARD = 1'b0,
    RND_EVEN  = 1'b1
  } rnd_mode_e;

  typedef struct packed {
    logic [NARROW_W-1:0] data;
    logic                nan;
    logic                ovf;
  } narrow_res_t;
endpackage

// File: rtl/f2b_classify.sv
module f2b_classify #(
  parameter int unsigned WIDE_W = 32,
  parameter int unsigned EXP_W  = 8
) (
  input  logic [WIDE_W-1:0] word_i,
  output logic              is_nan_o,
  output logic              is_finite_o
);
  localparam int unsigned FRAC_W = WIDE_W - 1 - EXP_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f       = word_i[WIDE_W-2 -: EXP_W];
  assign frac_f      = word_i[FRAC_W-1:0];
  assign is_nan_o    = (&exp_f) && (|frac_f);
  assign is_finite_o = ~(&exp_f);
endmodule

// File: rtl/f2b_round.sv
module f2b_round
  import f2b_pkg::*;
(
  input  logic [WIDE_W-1:0]   word_i,
  input  rnd_mode_e           mode_i,
  input  logic                is_nan_i,
  input  logic                is_finite_i,
  output narrow_res_t         res_o
);
  localparam int unsigned QUIET_BIT = FRAC_N - 1;

  logic [NARROW_W-1:0] upper;
  logic [NARROW_W-1:0] guard_sum;
  logic [WIDE_W-1:0]   even_sum;
  logic [NARROW_W-1:0] rounded;
  logic [NARROW_W-1:0] quiet;

  assign upper     = word_i[WIDE_W-1 -: NARROW_W];
  assign guard_sum = upper + NARROW_W'(word_i[DROP_W-1]);
  // bias of half-ulp minus one, plus the kept lsb, breaks ties toward even
  assign even_sum  = word_i + WIDE_W'({(DROP_W-1){1'b1}}) + WIDE_W'(word_i[DROP_W]);

  always_comb begin
    quiet            = upper;
    quiet[QUIET_BIT] = 1'b1;
    rounded = (mode_i == RND_EVEN) ? even_sum[WIDE_W-1 -: NARROW_W] : guard_sum;
  end

  always_comb begin
    if (is_nan_i) begin
      res_o.data = quiet;
      res_o.nan  = 1'b1;
      res_o.ovf  = 1'b0;
    end else begin
      res_o.data = rounded;
      res_o.nan  = 1'b0;
      res_o.ovf  = is_finite_i && (&rounded[NARROW_W-2 -: EXP_W]);
    end
  end
endmodule

// File: rtl/f2b_out_stage.sv
module f2b_out_stage
  import f2b_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_valid_i,
  output logic        load_ready_o,
  input  narrow_res_t load_res_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output narrow_res_t out_res_o
);
  logic take;

  assign load_ready_o = out_ready_i || !out_valid_o;
  assign take         = load_valid_i && load_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_res_o   <= '0;
    end else begin
      if (load_ready_o) out_valid_o <= load_valid_i;
      if (take)         out_res_o   <= load_res_i;
    end
  end

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_res_o)));

  assert_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (out_valid_o && out_res_o == $past(load_res_i)));

  assert_drain_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !load_valid_i) |=> !out_valid_o);
endmodule

// File: rtl/f32_bf16_narrow.sv
module f32_bf16_narrow
  import f2b_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [31:0] in_data_i,
  input  logic        in_mode_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [15:0] out_data_o,
  output logic        out_nan_o,
  output logic        out_ovf_o
);
  logic        is_nan;
  logic        is_finite;
  narrow_res_t comb_res;
  narrow_res_t reg_res;

  f2b_classify #(.WIDE_W(WIDE_W), .EXP_W(EXP_W)) u_class (
    .word_i      (in_data_i),
    .is_nan_o    (is_nan),
    .is_finite_o (is_finite)
  );

  f2b_round u_round (
    .word_i      (in_data_i),
    .mode_i      (rnd_mode_e'(in_mode_i)),
    .is_nan_i    (is_nan),
    .is_finite_i (is_finite),
    .res_o       (comb_res)
  );

  f2b_out_stage u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_valid_i (in_valid_i),
    .load_ready_o (in_ready_o),
    .load_res_i   (comb_res),
    .out_valid_o  (out_valid_o),
    .out_ready_i  (out_ready_i),
    .out_res_o    (reg_res)
  );

  assign out_data_o = reg_res.data;
  assign out_nan_o  = reg_res.nan;
  assign out_ovf_o  = reg_res.ovf;

  assert_nan_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_nan_o) |-> (&out_data_o[14:7] && out_data_o[6]));

  assert_nan_in_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && (in_data_i[30:0] > 31'h7F800000)) |=> out_nan_o);

  assert_ovf_inf_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ovf_o) |-> (out_data_o[14:0] == 15'h7F80));

  assert_flags_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_nan_o && out_ovf_o));

  assert_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_ready_i || !out_valid_o) |-> in_ready_o);
endmodule

// File: tb/tb_f32_bf16_narrow.sv
`timescale 1ns/1ps
module tb_f32_bf16_narrow;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_data_i = '0;
  logic        in_mode_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [15:0] out_data_o;
  logic        out_nan_o;
  logic        out_ovf_o;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;
  bit          stall_rand = 1'b0;
  bit          done = 1'b0;

  typedef struct {
    logic [15:0] data;
    logic        nan;
    logic        ovf;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk_i = ~clk_i;

  f32_bf16_narrow dut (.*);

  function automatic exp_t ref_model(input logic [31:0] x, input logic m);
    exp_t e;
    logic [31:0] s;
    e.nan = 1'b0;
    e.ovf = 1'b0;
    if (x[30:0] > 31'h7F800000) begin
      e.data = x[31:16] | 16'h0040;
      e.nan  = 1'b1;
      e.tag  = "R1";
    end else begin
      if (m) begin
        s = x + 32'h7FFF + {31'd0, x[16]};
        e.data = s[31:16];
        e.tag  = "R3";
      end else begin
        e.data = x[31:16] + {15'd0, x[15]};
        e.tag  = "R2";
      end
      if (x[30:23] != 8'hFF && e.data[14:7] == 8'hFF) begin
        e.ovf = 1'b1;
        e.tag = "R5";
      end
    end
    return e;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // driver: push expected at the accepting edge
  task automatic send(input logic [31:0] x, input logic m, input string tag = "");
    exp_t e;
    e = ref_model(x, m);
    if (tag != "") e.tag = tag;
    in_valid_i = 1'b1;
    in_data_i  = x;
    in_mode_i  = m;
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    sb.push_back(e);
    @(posedge clk_i);
    #1;
    in_valid_i = 1'b0;
  endtask

  // consumer back-pressure
  always @(posedge clk_i) begin
    #1;
    if (stall_rand) out_ready_i = ($urandom_range(0, 2) != 0);
  end

  // monitor
  logic        held_v = 1'b0;
  logic [17:0] held;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (held_v) begin
        check("R7 valid held", {31'd0, out_valid_o}, 32'd1);
        check("R7 data held", {14'd0, out_data_o, out_nan_o, out_ovf_o}, {14'd0, held});
      end
      held_v = out_valid_o && !out_ready_i;
      held   = {out_data_o, out_nan_o, out_ovf_o};
      if (out_valid_o && !out_ready_i)
        check("R8 ready low only when full and stalled", {31'd0, in_ready_o}, 32'd0);
      if (out_valid_o && out_ready_i) begin
        if (sb.size() == 0) begin
          check("R8 unexpected output", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " data"}, {16'd0, out_data_o}, {16'd0, e.data});
          check({e.tag, " nan flag"}, {31'd0, out_nan_o}, {31'd0, e.nan});
          check({e.tag, " ovf flag"}, {31'd0, out_ovf_o}, {31'd0, e.ovf});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R9 out_valid in reset", {31'd0, out_valid_o}, 32'd0);
    check("R9 nan in reset", {31'd0, out_nan_o}, 32'd0);
    check("R9 ovf in reset", {31'd0, out_ovf_o}, 32'd0);
    check("R8 ready when empty", {31'd0, in_ready_o}, 32'd1);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // directed
    send(32'h3E800000, 1'b0, "R4");
    send(32'h3E800000, 1'b1, "R4");
    send(32'h00000000, 1'b0, "R6");
    send(32'h80000000, 1'b1, "R6");
    send(32'h7F800000, 1'b0, "R6");
    send(32'hFF800000, 1'b1, "R6");
    send(32'h7F800000, 1'b1, "R6");
    send(32'h7FC00000, 1'b0, "R1");
    send(32'h7F800001, 1'b0, "R1");
    send(32'hFFA5FFFF, 1'b1, "R1");
    send(32'h7FFFFFFF, 1'b1, "R1");
    send(32'h3F808000, 1'b0, "R2");
    send(32'h3F808000, 1'b1, "R3");
    send(32'h3F818000, 1'b1, "R3");
    send(32'h3F807FFF, 1'b1, "R3");
    send(32'h7F7FFFFF, 1'b0, "R5");
    send(32'hFF7FFFFF, 1'b1, "R5");
    send(32'h7F7F8000, 1'b1, "R5");
    send(32'h7F7F7FFF, 1'b1, "R5");
    send(32'h7F7E8000, 1'b1, "R5");
    send(32'h7F7F0000, 1'b0, "R5");

    // stream at full rate
    for (int i = 0; i < 8; i++) begin
      in_valid_i = 1'b1;
      in_data_i  = 32'h40000000 + i * 32'h9001;
      in_mode_i  = i[0];
      @(negedge clk_i);
      check("R8 stream ready", {31'd0, in_ready_o}, 32'd1);
      sb.push_back(ref_model(in_data_i, in_mode_i));
      @(posedge clk_i); #1;
    end
    in_valid_i = 1'b0;

    // random with back-pressure
    stall_rand = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] x;
      x = $urandom;
      if (i % 7 == 0) x[30:23] = 8'hFF;
      if (i % 11 == 0) x[30:16] = 15'h7F7F;
      if (i % 13 == 0) x[15:0] = 16'h8000;
      send(x, $urandom_range(0, 1));
    end
    stall_rand = 1'b0;
    @(posedge clk_i); #1;
    out_ready_i = 1'b1;
    repeat (5) @(posedge clk_i);
    check("R8 scoreboard drained", sb.size(), 32'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule